// File: doc/BRIEF.md
# Beat-Signal Edge Time-Stamper

This block is the front end of a dual-mixer time-difference phase detector. It lives wholly in a helper clock domain. The helper clock runs a tiny fraction slower than the reference clock being measured, so sampling the reference on each helper rising edge gives a slow beat waveform. With a 125 MHz reference and a helper offset by one part in 32768, one beat cycle lasts about 32768 helper cycles. Two flip-flops in series do the sampling. The output of the second one is the beat.

A free-running counter advances on every helper edge. When the beat shows a clean rising edge, the block latches the counter value as a tag and raises a strobe for one cycle. Near each beat transition the sampled reference bounces because of metastability and jitter. To suppress this, a blanking counter is reloaded on every helper cycle in which the beat is high. A rising edge is tagged only once that counter has drained to zero. Only the first edge of a burst is therefore tagged. Later processing compares tags from two such front ends, or successive tags of one front end, to obtain phase and period.

The blanking length `BLIND` (default 200) and the counter width `CNT_W` (default 32, wraps modulo 2^CNT_W) are parameters. Edge indices below count helper rising edges with `rst_n` high, starting at 0 for the first such edge after reset.

Top module: `beat_tagger`

## Requirements
- R1: A reference sample taken at edge s appears on the beat at edge s+1. A beat rise caused by `ref_clk_i` going from low at edge s-1 to high at edge s is therefore reported by `tag_vld_o` rising just after edge s+1.
- R2: The tag reported for a capture at edge m equals m modulo 2^CNT_W, which is the free-running counter value on that edge.
- R3: `tag_vld_o` stays high for exactly one helper cycle per capture and is low on every other cycle.
- R4: Between captures, `tag_o` keeps the value of the most recent capture.
- R5: Let h be the last edge before s at which `ref_clk_i` was sampled high. A rise (low at s-1, high at s) is tagged when s - h >= BLIND - 1, or when there was no such sample since reset.
- R6: A rise with s - h < BLIND - 1 produces no strobe and leaves `tag_o` unchanged.
- R7: Each high sample restarts the blanking window. In a burst of alternating samples, only the first rise is tagged, and the next tag needs BLIND - 1 samples after the last high one.
- R8: Synchronous active-low reset clears the sampler, the counter, the blanking counter, `tag_vld_o` and `tag_o`. Numbering of tags restarts at 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_hlp | input | 1 | Helper clock; every register runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, sampled as data |
| tag_o | output | CNT_W | Counter value latched at the last accepted beat rise |
| tag_vld_o | output | 1 | One-cycle strobe marking a new tag |

## Verification
The bench attacks the blanking boundary from both sides: a rise exactly BLIND-1 samples after the last high sample must be tagged, and one sample sooner must not. A design that applied the reload and the decrement in separate cycles, or compared against the wrong bound, would gain or lose a tag at this boundary. Bursts of alternating samples before a long high stretch check that every high sample reloads the window. A counter that reloaded only on the first high sample would tag the late bounces. Exact tag values, checked before and after a mid-run reset, expose a one-cycle error in the sampler depth, a counter that is read after it increments, and a counter that does not restart on reset.

// File: rtl/beat_tagger_pkg.sv
// Package: shared defaults and width helpers for the beat time-stamper.
// Assumes: nothing beyond elaboration-time constants.
package beat_tagger_pkg;

    localparam int unsigned DEF_BLIND = 200;
    localparam int unsigned DEF_CNT_W = 32;

    // Bits needed to hold values 0 .. n-1, never less than one.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/beat_sampler.sv
// Module: beat_sampler
// Samples the reference clock through two flip-flops in series on the
// helper clock. Outputs the first-stage sample (the beat value of the next
// cycle) and the beat itself.
// Assumes: ref_clk_i is asynchronous to clk_hlp; no glitch filtering here.
module beat_sampler (
    input  logic clk_hlp,
    input  logic rst_n,
    input  logic ref_clk_i,
    output logic stage1_o,
    output logic beat_o
);

    // Two-stage shift of the reference sample.
    always_ff @(posedge clk_hlp) begin
        if (!rst_n) begin
            stage1_o <= 1'b0;
            beat_o   <= 1'b0;
        end else begin
            stage1_o <= ref_clk_i;
            beat_o   <= stage1_o;
        end
    end

endmodule

// File: rtl/tag_timebase.sv
// Module: tag_timebase
// Free-running helper-domain counter. The value on a given edge is the
// number of edges since reset release, wrapping modulo 2^CNT_W.
// Assumes: the consumer samples count_o on the same edge it acts on.
module tag_timebase #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_hlp,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o
);

    // Advance by one every helper cycle out of reset.
    always_ff @(posedge clk_hlp) begin
        if (!rst_n) count_o <= '0;
        else        count_o <= count_o + CNT_W'(1);
    end

endmodule

// File: rtl/first_edge_gate.sv
// Module: first_edge_gate
// Decides whether the beat edge arriving on this clock is the first edge of
// a burst. The blanking counter is loaded with BLIND-1 on every high beat
// sample and decremented in the same cycle, so it settles at BLIND-2. A rise
// is accepted only while the counter is zero.
// Assumes: beat_next_i is the value the beat takes on this edge, and
// beat_cur_i is its value before the edge.
module first_edge_gate
    import beat_tagger_pkg::*;
#(
    parameter int unsigned BLIND = DEF_BLIND,
    localparam int unsigned BW   = cnt_bits(BLIND)
) (
    input  logic          clk_hlp,
    input  logic          rst_n,
    input  logic          beat_next_i,
    input  logic          beat_cur_i,
    output logic          fire_o,
    output logic [BW-1:0] blank_o
);

    logic rise;

    // A rise: the beat was low and is about to be high.
    assign rise   = beat_next_i & ~beat_cur_i;
    assign fire_o = rise & (blank_o == '0);

    generate
        if (BLIND <= 2) begin : g_no_blank
            // Reload-then-decrement leaves nothing to count.
            assign blank_o = '0;
        end else begin : g_blank
            localparam logic [BW-1:0] SETTLE = BW'(BLIND - 2);
            // Reload on a high sample, otherwise drain towards zero.
            always_ff @(posedge clk_hlp) begin
                if (!rst_n)               blank_o <= '0;
                else if (beat_next_i)     blank_o <= SETTLE;
                else if (blank_o != '0)   blank_o <= blank_o - BW'(1);
            end
        end
    endgenerate

endmodule

// File: rtl/beat_tagger.sv
// Module: beat_tagger (top)
// Helper-domain time-stamper: it samples the reference clock into a beat
// and tags the first rising edge of each beat burst with the free-running
// counter value. It issues a one-cycle strobe with each tag.
// Assumes: the helper clock is slightly offset from the reference; crossing
// tags into another domain is left to the consumer.
module beat_tagger
    import beat_tagger_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned BLIND = DEF_BLIND,
    localparam int unsigned BW   = cnt_bits(BLIND)
) (
    input  logic             clk_hlp,
    input  logic             rst_n,
    input  logic             ref_clk_i,
    output logic [CNT_W-1:0] tag_o,
    output logic             tag_vld_o
);

    logic             stage1;
    logic             beat;
    logic             fire;
    logic [BW-1:0]    blank_cnt;
    logic [CNT_W-1:0] now;

    beat_sampler u_sampler (
        .clk_hlp   (clk_hlp),
        .rst_n     (rst_n),
        .ref_clk_i (ref_clk_i),
        .stage1_o  (stage1),
        .beat_o    (beat)
    );

    tag_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk_hlp (clk_hlp),
        .rst_n   (rst_n),
        .count_o (now)
    );

    first_edge_gate #(.BLIND(BLIND)) u_gate (
        .clk_hlp     (clk_hlp),
        .rst_n       (rst_n),
        .beat_next_i (stage1),
        .beat_cur_i  (beat),
        .fire_o      (fire),
        .blank_o     (blank_cnt)
    );

    // Latch the counter on an accepted rise and pulse the strobe.
    always_ff @(posedge clk_hlp) begin
        if (!rst_n) begin
            tag_o     <= '0;
            tag_vld_o <= 1'b0;
        end else begin
            tag_vld_o <= fire;
            if (fire) tag_o <= now;
        end
    end

endmodule

// File: rtl/beat_tagger_chk.sv
// Module: beat_tagger_chk
// Property checker for beat_tagger, attached by bind. It tracks the spacing
// between observed strobes with its own counter.
// Assumes: bound inside beat_tagger, where blank_cnt is visible.
module beat_tagger_chk
    import beat_tagger_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned BLIND = DEF_BLIND,
    localparam int unsigned BW   = cnt_bits(BLIND),
    localparam int unsigned MIN_GAP = (BLIND > 3) ? BLIND - 1 : 2
) (
    input logic             clk_hlp,
    input logic             rst_n,
    input logic [CNT_W-1:0] tag_o,
    input logic             tag_vld_o,
    input logic [BW-1:0]    blank_cnt
);

    logic [CNT_W-1:0] since;
    logic [CNT_W-1:0] last_tag;
    logic             have_prev;

    // Edges elapsed since the last observed capture, and that capture's tag.
    always_ff @(posedge clk_hlp) begin
        if (!rst_n) begin
            since     <= '0;
            last_tag  <= '0;
            have_prev <= 1'b0;
        end else if (tag_vld_o) begin
            since     <= CNT_W'(1);
            last_tag  <= tag_o;
            have_prev <= 1'b1;
        end else begin
            since     <= since + CNT_W'(1);
        end
    end

    // R3: strobe never lasts two cycles.
    p_single_strobe_r3: assert property (@(posedge clk_hlp) disable iff (!rst_n)
        tag_vld_o |=> !tag_vld_o);

    // R4: tag holds while no strobe.
    p_tag_hold_r4: assert property (@(posedge clk_hlp) disable iff (!rst_n)
        !tag_vld_o |-> $stable(tag_o));

    // R5: a capture happens only with the blanking counter drained.
    p_blank_clear_r5: assert property (@(posedge clk_hlp) disable iff (!rst_n)
        tag_vld_o |-> ($past(blank_cnt) == '0));

    // R2: tag difference between captures equals edges elapsed.
    p_tag_step_r2: assert property (@(posedge clk_hlp) disable iff (!rst_n)
        (tag_vld_o && have_prev) |-> ((tag_o - last_tag) == since));

    // R7: captures are spaced by at least the blanking window.
    p_min_gap_r7: assert property (@(posedge clk_hlp) disable iff (!rst_n)
        (tag_vld_o && have_prev) |-> (since >= CNT_W'(MIN_GAP)));

    // R8: a reset cycle leaves the outputs cleared.
    p_reset_clear_r8: assert property (@(posedge clk_hlp)
        !rst_n |=> (!tag_vld_o && tag_o == '0));

endmodule

bind beat_tagger beat_tagger_chk #(.CNT_W(CNT_W), .BLIND(BLIND)) u_chk (
    .clk_hlp   (clk_hlp),
    .rst_n     (rst_n),
    .tag_o     (tag_o),
    .tag_vld_o (tag_vld_o),
    .blank_cnt (blank_cnt)
);

// File: tb/beat_tagger_bench.sv
// Scoreboard bench: the driver predicts each tag from the requirements and
// queues it; the monitor compares strobes and held tags at falling edges.
module beat_tagger_bench;

    localparam int unsigned CNT_W = 32;
    localparam int unsigned BLIND = 200;
    localparam int          NEVER = -1000000;

    typedef struct {
        int               edge_idx;
        logic [CNT_W-1:0] tag;
        string            req;
    } exp_t;

    logic             clk_hlp = 1'b0;
    logic             rst_n   = 1'b0;
    logic             ref_clk_i = 1'b0;
    logic [CNT_W-1:0] tag_o;
    logic             tag_vld_o;

    int    total = 0;
    int    bad   = 0;
    int    edges = 0;
    int    cyc   = 0;
    exp_t  q[$];
    bit    prev_v = 1'b0;
    int    last_high = NEVER;
    string cur_req = "R4";
    logic [CNT_W-1:0] held = '0;
    logic  prev_vld = 1'b0;

    always #2 clk_hlp = ~clk_hlp;

    beat_tagger #(.CNT_W(CNT_W), .BLIND(BLIND)) u_beat_tagger (
        .clk_hlp   (clk_hlp),
        .rst_n     (rst_n),
        .ref_clk_i (ref_clk_i),
        .tag_o     (tag_o),
        .tag_vld_o (tag_vld_o)
    );

    // Edge index: edges seen with reset released.
    always @(posedge clk_hlp) begin
        cyc <= cyc + 1;
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    // Driver: one reference sample per cycle, with its predicted capture.
    task automatic step(input bit v, input string req);
        @(negedge clk_hlp);
        ref_clk_i = v;
        cur_req   = req;
        if (v && !prev_v && (last_high == NEVER || edges - last_high >= BLIND - 1))
            q.push_back('{edges + 1, CNT_W'(edges + 1), req});
        if (v) last_high = edges;
        prev_v = v;
    endtask

    task automatic hold(input bit v, input int n, input string req);
        for (int i = 0; i < n; i++) step(v, req);
    endtask

    // Monitor: compare strobes against the queue and check tag holding.
    always @(negedge clk_hlp) begin
        if (rst_n && edges > 0) begin
            while (q.size() > 0 && q[0].edge_idx < edges - 1) begin
                total++; bad++;
                $display("FAIL %s missed tag: actual=none expected=%0d", q[0].req, q[0].tag);
                void'(q.pop_front());
            end
            if (tag_vld_o) begin
                total++;
                if (prev_vld) begin
                    bad++;
                    $display("FAIL R3 strobe two cycles: actual=1 expected=0");
                end
                if (q.size() == 0 || q[0].edge_idx != edges - 1) begin
                    bad++;
                    $display("FAIL %s unexpected tag: actual=%0d expected=none", cur_req, tag_o);
                end else begin
                    total++;
                    if (tag_o !== q[0].tag) begin
                        bad++;
                        $display("FAIL %s tag value: actual=%0d expected=%0d", q[0].req, tag_o, q[0].tag);
                    end
                    void'(q.pop_front());
                end
                held = tag_o;
            end else begin
                total++;
                if (tag_o !== held) begin
                    bad++;
                    $display("FAIL %s tag not held: actual=%0d expected=%0d", cur_req, tag_o, held);
                end
            end
            prev_vld = tag_vld_o;
        end
    end

    task automatic do_reset();
        @(negedge clk_hlp);
        rst_n = 1'b0;
        ref_clk_i = 1'b0;
        repeat (3) @(negedge clk_hlp);
        total++;
        if (tag_vld_o !== 1'b0 || tag_o !== '0) begin
            bad++;
            $display("FAIL R8 reset state: actual=%0d/%0d expected=0/0", tag_vld_o, tag_o);
        end
        prev_v = 1'b0; last_high = NEVER; held = '0; prev_vld = 1'b0;
        q.delete();
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        wait (cyc > 60000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 R2 R5: clean beat with long gaps, every rise tagged.
        hold(0, 5, "R1");
        hold(1, 50, "R2");
        hold(0, 250, "R5");
        hold(1, 50, "R2");
        hold(0, 250, "R5");
        // R7: chatter at the edge, only the first rise tagged.
        step(1, "R7"); step(0, "R7"); step(1, "R7"); hold(0, 2, "R7");
        hold(1, 3, "R7"); step(0, "R7");
        hold(1, 60, "R7");
        hold(0, 250, "R7");
        // R5: rise exactly BLIND-1 samples after the last high one is tagged.
        hold(1, 10, "R5");
        hold(0, BLIND - 2, "R5");
        hold(1, 10, "R5");
        // R6: one sample earlier is ignored and the tag stays put.
        hold(0, BLIND - 3, "R6");
        hold(1, 10, "R6");
        hold(0, 300, "R6");
        // R8: reset mid-run restarts tag numbering.
        do_reset();
        hold(0, 3, "R8");
        hold(1, 20, "R8");
        hold(0, 250, "R8");
        hold(1, 20, "R2");
        hold(0, 20, "R4");
        if (q.size() != 0) begin
            total++; bad++;
            $display("FAIL R2 pending tags: actual=%0d expected=0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule